// File: doc/BRIEF.md
# General-Purpose I/O Port with Atomic Bit Set/Clear

This block is one 16-pin I/O port that sits on a simple 32-bit memory-mapped bus. Software selects per pin whether the pad is driven, and picks a drive-speed code for each pin. It writes the output level either as a whole word or through a write-only set/clear register. A synchronized copy of the pin levels can be read back.

The set/clear register lets any number of output bits be raised or lowered in a single bus write. Two software contexts that share the port therefore never need a load-modify-store sequence, and one context cannot overwrite the other's changes. The output data register keeps a fixed offset of 0x14 inside the port window. A bit-level alias unit upstream can then compute addresses that land on it.

The port window is 1 KiB wide and starts at parameter `BASE`, which defaults to 0x4002_0000. Reads return data one cycle after the request, together with a valid strobe.

Top module: `gpio_port`

## Requirements
- R1: After reset the mode, speed and output registers are zero. This means `pad_out`, `pad_oe` and `pad_speed` are all zero, and a read of the mode register at offset 0x00 returns zero.
- R2: The mode register at offset 0x00 is read/write and holds a 2-bit field for pin n at bits 2n+1:2n. `pad_oe[n]` is 1 exactly when that field equals 2'b01.
- R3: The speed register at offset 0x08 is read/write and holds a 2-bit field for pin n at bits 2n+1:2n, where 2'b11 is the fastest. It drives `pad_speed` directly.
- R4: The output data register at offset 0x14 is read/write. Its bits 15:0 drive `pad_out`, and they hold their value on every cycle without a write that hits them.
- R5: A write to the set/clear register at offset 0x18 sets output bit n where wdata bit n is 1 and clears output bit n where wdata bit n+16 is 1. Bits with both controls at 0 keep their value, and several pins may change in one write.
- R6: When wdata bits n and n+16 are both 1 in one set/clear write, output bit n becomes 1.
- R7: The set/clear register reads back as zero.
- R8: The input register at offset 0x10 returns `pin_in` through a two-flop synchronizer. A pin change made in the cycle of a read request is not yet visible in that read. Writes to the input register have no effect.
- R9: An access whose address lies outside the 1 KiB window at `BASE`, or that hits no register, changes no register, and a read of it returns zero.
- R10: `bus_rvalid` is 1 in the cycle after each cycle in which `bus_rd` is 1, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 32 | Byte address of the access |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read request |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after the request |
| pin_in | input | 16 | Asynchronous pin levels |
| pad_out | output | 16 | Output level for each pad |
| pad_oe | output | 16 | Output enable for each pad |
| pad_speed | output | 32 | 2-bit speed code for each pad |

## Verification
The set/clear register is tested with several patterns. A set-only and clear-only mix on different pins shows that each half acts on its own pins. An all-zero write must leave the output unchanged, which separates a masked update from a plain store. A write with both controls on the same pin tells the set-priority rule apart from the clear-priority rule. The mode register gets a mix of all four field codes, so an enable decoded from only one bit of the field would show up. The input register is read first in the same cycle as a pin change and then after settling, which confirms the synchronizer delay. Out-of-window writes and reads confirm the address decode.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
   // window and register offsets (byte addresses inside the port window)
   localparam int unsigned WIN_BITS = 10;
   localparam logic [WIN_BITS-1:0] OFS_MODE   = 10'h000;
   localparam logic [WIN_BITS-1:0] OFS_SPEED  = 10'h008;
   localparam logic [WIN_BITS-1:0] OFS_IN     = 10'h010;
   localparam logic [WIN_BITS-1:0] OFS_OUT    = 10'h014;
   localparam logic [WIN_BITS-1:0] OFS_SETCLR = 10'h018;

   localparam logic [1:0] MODE_OUTPUT = 2'b01;

   typedef enum logic [2:0] {
      SEL_NONE,
      SEL_MODE,
      SEL_SPEED,
      SEL_IN,
      SEL_OUT,
      SEL_SETCLR
   } reg_sel_e;
endpackage

// File: rtl/gpio_bus_decode.sv
module gpio_bus_decode
   import gpio_port_pkg::*;
#(
   parameter int unsigned AW = 32,
   parameter logic [AW-1:0] BASE = 32'h4002_0000
) (
   input  logic [AW-1:0] addr,
   output reg_sel_e      sel
);
   logic in_window;

   assign in_window = (addr[AW-1:WIN_BITS] == BASE[AW-1:WIN_BITS]);

   always_comb begin
      sel = SEL_NONE;
      if (in_window) begin
         unique case (addr[WIN_BITS-1:0])
            OFS_MODE:   sel = SEL_MODE;
            OFS_SPEED:  sel = SEL_SPEED;
            OFS_IN:     sel = SEL_IN;
            OFS_OUT:    sel = SEL_OUT;
            OFS_SETCLR: sel = SEL_SETCLR;
            default:    sel = SEL_NONE;
         endcase
      end
   end
endmodule

// File: rtl/gpio_sync.sv
module gpio_sync #(
   parameter int unsigned W      = 16,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] chain [STAGES];

   always_ff @(posedge clk) chain[0] <= d;

   generate
      for (genvar s = 1; s < STAGES; s++) begin : g_stage
         always_ff @(posedge clk) chain[s] <= chain[s-1];
      end
   endgenerate

   assign q = chain[STAGES-1];
endmodule

// File: rtl/gpio_out_reg.sv
module gpio_out_reg #(
   parameter int unsigned NPINS = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_full,
   input  logic             wr_masked,
   input  logic [NPINS-1:0] full_val,
   input  logic [NPINS-1:0] set_mask,
   input  logic [NPINS-1:0] clr_mask,
   output logic [NPINS-1:0] q
);
   logic [NPINS-1:0] nxt;

   // clear first, then set: a pin named in both masks ends up high
   always_comb begin
      nxt = q;
      if (wr_full)        nxt = full_val;
      else if (wr_masked) nxt = (q & ~clr_mask) | set_mask;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) q <= '0;
      else        q <= nxt;
   end
endmodule

// File: rtl/gpio_port.sv
module gpio_port
   import gpio_port_pkg::*;
#(
   parameter int unsigned NPINS       = 16,
   parameter int unsigned AW          = 32,
   parameter int unsigned DW          = 32,
   parameter int unsigned SYNC_STAGES = 2,
   parameter logic [AW-1:0] BASE      = 32'h4002_0000
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [AW-1:0]      bus_addr,
   input  logic               bus_wr,
   input  logic [DW-1:0]      bus_wdata,
   input  logic               bus_rd,
   output logic [DW-1:0]      bus_rdata,
   output logic               bus_rvalid,
   input  logic [NPINS-1:0]   pin_in,
   output logic [NPINS-1:0]   pad_out,
   output logic [NPINS-1:0]   pad_oe,
   output logic [2*NPINS-1:0] pad_speed
);
   localparam int unsigned FW = 2 * NPINS;

   generate
      if (DW < FW) begin : g_bad_width
         $error("gpio_port: DW must hold two bits per pin");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("gpio_port: SYNC_STAGES must be at least 2");
      end
      if (AW <= WIN_BITS) begin : g_bad_aw
         $error("gpio_port: AW too small for the port window");
      end
   endgenerate

   reg_sel_e         sel;
   logic [FW-1:0]    mode_q;
   logic [FW-1:0]    speed_q;
   logic [NPINS-1:0] in_q;
   logic [NPINS-1:0] out_q;
   logic [DW-1:0]    rd_mux;

   gpio_bus_decode #(.AW(AW), .BASE(BASE)) u_dec (
      .addr (bus_addr),
      .sel  (sel)
   );

   gpio_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
      .clk (clk),
      .d   (pin_in),
      .q   (in_q)
   );

   gpio_out_reg #(.NPINS(NPINS)) u_out (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_full   (bus_wr && sel == SEL_OUT),
      .wr_masked (bus_wr && sel == SEL_SETCLR),
      .full_val  (bus_wdata[NPINS-1:0]),
      .set_mask  (bus_wdata[NPINS-1:0]),
      .clr_mask  (bus_wdata[FW-1:NPINS]),
      .q         (out_q)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q  <= '0;
         speed_q <= '0;
      end else if (bus_wr) begin
         if (sel == SEL_MODE)  mode_q  <= bus_wdata[FW-1:0];
         if (sel == SEL_SPEED) speed_q <= bus_wdata[FW-1:0];
      end
   end

   generate
      for (genvar p = 0; p < NPINS; p++) begin : g_oe
         assign pad_oe[p] = (mode_q[2*p +: 2] == MODE_OUTPUT);
      end
   endgenerate

   always_comb begin
      unique case (sel)
         SEL_MODE:  rd_mux = DW'(mode_q);
         SEL_SPEED: rd_mux = DW'(speed_q);
         SEL_IN:    rd_mux = DW'(in_q);
         SEL_OUT:   rd_mux = DW'(out_q);
         default:   rd_mux = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bus_rdata  <= '0;
         bus_rvalid <= 1'b0;
      end else begin
         bus_rdata  <= bus_rd ? rd_mux : '0;
         bus_rvalid <= bus_rd;
      end
   end

   assign pad_out   = out_q;
   assign pad_speed = speed_q;
endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk
   import gpio_port_pkg::*;
#(
   parameter int unsigned NPINS       = 16,
   parameter int unsigned AW          = 32,
   parameter int unsigned DW          = 32,
   parameter int unsigned SYNC_STAGES = 2,
   parameter logic [AW-1:0] BASE      = 32'h4002_0000
) (
   input logic               clk,
   input logic               rst_n,
   input logic [AW-1:0]      bus_addr,
   input logic               bus_wr,
   input logic [DW-1:0]      bus_wdata,
   input logic               bus_rd,
   input logic [DW-1:0]      bus_rdata,
   input logic               bus_rvalid,
   input logic [NPINS-1:0]   pin_in,
   input logic [NPINS-1:0]   pad_out,
   input logic [NPINS-1:0]   pad_oe,
   input logic [2*NPINS-1:0] pad_speed
);
   logic                hit;
   logic [WIN_BITS-1:0] ofs;
   logic [NPINS-1:0]    w_set;
   logic [NPINS-1:0]    w_clr;

   assign hit   = (bus_addr[AW-1:WIN_BITS] == BASE[AW-1:WIN_BITS]);
   assign ofs   = bus_addr[WIN_BITS-1:0];
   assign w_set = bus_wdata[NPINS-1:0];
   assign w_clr = bus_wdata[2*NPINS-1:NPINS];

   function automatic logic [NPINS-1:0] enables_of(input logic [DW-1:0] m);
      logic [NPINS-1:0] r;
      for (int p = 0; p < NPINS; p++) r[p] = (m[2*p +: 2] == 2'b01);
      return r;
   endfunction

   // R2
   oe_after_mode_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && hit && ofs == OFS_MODE) |=> (pad_oe == enables_of($past(bus_wdata))));

   // R5
   setclr_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && hit && ofs == OFS_SETCLR)
         |=> (pad_out == (($past(pad_out) & ~$past(w_clr)) | $past(w_set))));

   // R4
   out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_wr |=> $stable(pad_out));

   // R7
   setclr_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && hit && ofs == OFS_SETCLR) |=> (bus_rdata == '0));

   // R9
   outside_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && !hit) |=> ($stable(pad_out) && $stable(pad_oe) && $stable(pad_speed)));

   // R10
   rvalid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rd |=> bus_rvalid);

   // R10
   rvalid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_rd |=> !bus_rvalid);
endmodule

bind gpio_port gpio_port_chk #(
   .NPINS(NPINS), .AW(AW), .DW(DW), .SYNC_STAGES(SYNC_STAGES), .BASE(BASE)
) u_chk (.*);

// File: tb/tb_gpio_port.sv
module tb_gpio_port;
   localparam time CLK_PERIOD = 10ns;
   localparam logic [31:0] BASE = 32'h4002_0000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] bus_addr = '0;
   logic        bus_wr = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic        bus_rd = 1'b0;
   logic [31:0] bus_rdata;
   logic        bus_rvalid;
   logic [15:0] pin_in = '0;
   logic [15:0] pad_out;
   logic [15:0] pad_oe;
   logic [31:0] pad_speed;

   int checks = 0;
   int fails  = 0;

   typedef struct {
      logic [31:0] data;
      string       tag;
   } exp_t;
   exp_t sb[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   gpio_port dut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
      .bus_rvalid(bus_rvalid), .pin_in(pin_in), .pad_out(pad_out),
      .pad_oe(pad_oe), .pad_speed(pad_speed)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // tasks are entered at a falling edge and return at the next falling edge
   task automatic bus_write(input logic [31:0] a, input logic [31:0] d);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic bus_read(input logic [31:0] a, input logic [31:0] exp, input string tag);
      exp_t e;
      e.data = exp; e.tag = tag;
      sb.push_back(e);
      bus_addr = a; bus_rd = 1'b1;
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   // monitor: every returned read is compared against the oldest expectation
   always @(negedge clk) begin
      if (rst_n && bus_rvalid) begin
         if (sb.size() == 0) begin
            check("R10 unexpected rvalid", 32'd1, 32'd0);
         end else begin
            exp_t e;
            e = sb.pop_front();
            check(e.tag, bus_rdata, e.data);
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      check("R1 pad_out", 32'(pad_out), 32'h0);
      check("R1 pad_oe", 32'(pad_oe), 32'h0);
      check("R1 pad_speed", pad_speed, 32'h0);
      check("R10 idle rvalid", 32'(bus_rvalid), 32'h0);
      bus_read(BASE + 32'h00, 32'h0, "R1 mode read");

      // R2: pin0=01 pin1=10 pin2=11 pin3=01 -> enables on pins 0 and 3
      bus_write(BASE + 32'h00, 32'h0000_0079);
      check("R2 pad_oe", 32'(pad_oe), 32'h0000_0009);
      bus_read(BASE + 32'h00, 32'h0000_0079, "R2 mode readback");

      // R3
      bus_write(BASE + 32'h08, 32'hC000_0003);
      check("R3 pad_speed", pad_speed, 32'hC000_0003);
      bus_read(BASE + 32'h08, 32'hC000_0003, "R3 speed readback");

      // R4
      bus_write(BASE + 32'h14, 32'h0000_00F0);
      check("R4 pad_out", 32'(pad_out), 32'h0000_00F0);
      bus_read(BASE + 32'h14, 32'h0000_00F0, "R4 out readback");

      // R5: set pin 8, clear pin 4
      bus_write(BASE + 32'h18, 32'h0010_0100);
      check("R5 mixed set/clear", 32'(pad_out), 32'h0000_01E0);
      // R5: empty write keeps everything
      bus_write(BASE + 32'h18, 32'h0000_0000);
      check("R5 empty write", 32'(pad_out), 32'h0000_01E0);
      // R5: several clears at once
      bus_write(BASE + 32'h18, 32'h0060_0000);
      check("R5 multi clear", 32'(pad_out), 32'h0000_0180);

      // R6: pin 0 both set and clear -> high; pin 7 cleared
      bus_write(BASE + 32'h18, 32'h0081_0001);
      check("R6 set wins", 32'(pad_out), 32'h0000_0101);
      bus_read(BASE + 32'h14, 32'h0000_0101, "R6 out readback");

      // R7
      bus_read(BASE + 32'h18, 32'h0, "R7 setclr reads zero");

      // R8: change pins in the same cycle as a read request -> old value
      pin_in = 16'hA5A5;
      bus_read(BASE + 32'h10, 32'h0, "R8 sync delay");
      @(negedge clk);
      @(negedge clk);
      bus_read(BASE + 32'h10, 32'h0000_A5A5, "R8 input settled");
      bus_write(BASE + 32'h10, 32'h0000_FFFF);
      bus_read(BASE + 32'h10, 32'h0000_A5A5, "R8 input write ignored");
      check("R8 pad_out untouched", 32'(pad_out), 32'h0000_0101);

      // R9: outside the window
      bus_write(32'h4003_0014, 32'h0000_FFFF);
      check("R9 pad_out", 32'(pad_out), 32'h0000_0101);
      bus_write(32'h4003_0000, 32'h5555_5555);
      check("R9 pad_oe", 32'(pad_oe), 32'h0000_0009);
      bus_read(32'h4003_0014, 32'h0, "R9 outside read");
      bus_read(BASE + 32'h04, 32'h0, "R9 unmapped read");

      @(negedge clk);
      check("R10 rvalid drops", 32'(bus_rvalid), 32'h0);
      check("R10 scoreboard drained", 32'(sb.size()), 32'h0);

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule